// File: doc/BRIEF.md
# Exception Entry State Updater

This block computes and registers the processor state that results when a soft processor core takes an exception. The core presents its current status word, program counter and translation-miscellaneous word. It also presents a cause code, a flag that marks a breakpoint entry, the handler vector address, and a set of translation-miscellaneous bits to merge in. On the edge where the take strobe is sampled high, the block produces the new status word, the saved status copy, the link address, the exception register, the new translation-miscellaneous word, the new program counter and the active register bank.

Breakpoint entries use their own pair of save registers. Nested entries leave the saved copies alone: a nested entry is one taken while the handler-active bit is already set. The `MMU_EN` parameter selects whether the translation unit is present. When it is present, the first-level entry sets the handler-active bit. It also rewrites a group of four translation status bits.

Top module: `exc_entry_upd`

## Requirements
- R1: On every entry the current-register-set field of the new status (bits 15:10) is 0, and the active bank output is 0.
- R2: The old status and the PC are saved only when the handler-active bit (status bit 2) of the old status is 0. When that bit is 1, all four save outputs keep their values.
- R3: On a break entry (brk_i=1) the old status goes to bstatus_o and pc_i goes to ba_o. On any other entry they go to estatus_o and ea_o.
- R4: With the translation unit present and old bit 2 clear, the new status has bit 2 set. The new translation word is (tlbmisc_i with bits 3:0 cleared) OR tlb_set_i. On a nested entry it is tlbmisc_i unchanged.
- R5: When old bit 2 is 0, the previous-register-set field (bits 21:16) of the new status takes the old bits 15:10. Otherwise that field is kept.
- R6: Bits 0 and 1 of the new status (interrupt enable, user mode) are always 0. Every status bit not named in R1, R4, R5 or R6 is copied from the old status.
- R7: A non-break entry sets exc_o to cause_i in bits 6:2 with zeros elsewhere. A break entry leaves exc_o unchanged.
- R8: The new PC equals vec_i.
- R9: While take_i is low, every output holds its value, whatever the other inputs do.
- R10: After reset every output is 0.
- R11: With the translation unit absent (MMU_EN=0), an entry never sets status bit 2, and tlbmisc_o takes tlbmisc_i unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | Take-exception strobe |
| brk_i | input | 1 | Entry is a breakpoint |
| cause_i | input | CAUSE_W | Exception cause code |
| vec_i | input | DATA_W | Handler vector address |
| pc_i | input | DATA_W | Current (return) PC |
| status_i | input | DATA_W | Current status word |
| tlbmisc_i | input | DATA_W | Current translation-miscellaneous word |
| tlb_set_i | input | DATA_W | Bits to OR into the translation word |
| status_o | output | DATA_W | New status word |
| estatus_o | output | DATA_W | Saved status, ordinary entries |
| bstatus_o | output | DATA_W | Saved status, break entries |
| exc_o | output | DATA_W | Exception register |
| ea_o | output | DATA_W | Link address, ordinary entries |
| ba_o | output | DATA_W | Link address, break entries |
| tlbmisc_o | output | DATA_W | New translation-miscellaneous word |
| pc_o | output | DATA_W | New PC |
| bank_o | output | RS_W | Active register bank |

## Verification
Clearing the current register set and copying it into the previous-set field happen in the same cycle, on the same source bits. The stimulus table therefore uses status words whose current-set field is nonzero and whose previous-set field already holds a different value. The checks compare both fields against independently computed expectations. A nested break entry is also applied directly after a first-level one. This confirms that the PC update and the held save registers coexist in one edge.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int ST_PIE      = 0;
    localparam int ST_USER     = 1;
    localparam int ST_HND      = 2;
    localparam int RS_W        = 6;
    localparam int ST_CUR_LSB  = 10;
    localparam int ST_PRV_LSB  = 16;
    localparam int TLB_CLR_W   = 4;
    localparam int EXC_LSB     = 2;
endpackage

// File: rtl/exc_stat_next.sv
module exc_stat_next
    import exc_entry_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit MMU_EN = 1'b1
) (
    input  logic [DATA_W-1:0] old_i,
    output logic [DATA_W-1:0] new_o,
    output logic              nested_o
);
    logic [DATA_W-1:0] s_d;

    always_comb begin
        s_d = old_i;
        s_d[ST_CUR_LSB +: RS_W] = '0;
        if (!old_i[ST_HND]) begin
            if (MMU_EN) begin
                s_d[ST_HND] = 1'b1;
            end
            s_d[ST_PRV_LSB +: RS_W] = old_i[ST_CUR_LSB +: RS_W];
        end
        s_d[ST_PIE]  = 1'b0;
        s_d[ST_USER] = 1'b0;
    end

    assign new_o    = s_d;
    assign nested_o = old_i[ST_HND];
endmodule

// File: rtl/exc_tlb_next.sv
module exc_tlb_next
    import exc_entry_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit MMU_EN = 1'b1
) (
    input  logic [DATA_W-1:0] tlb_i,
    input  logic [DATA_W-1:0] set_i,
    input  logic              nested_i,
    output logic [DATA_W-1:0] tlb_o
);
    localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'((1 << TLB_CLR_W) - 1);

    generate
        if (MMU_EN) begin : g_mmu
            assign tlb_o = nested_i ? tlb_i : ((tlb_i & ~CLR_MASK) | set_i);
        end else begin : g_nommu
            logic unused_bits;
            assign unused_bits = ^{set_i, nested_i};
            assign tlb_o = tlb_i;
        end
    endgenerate
endmodule

// File: rtl/exc_cause_fmt.sv
module exc_cause_fmt
    import exc_entry_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CAUSE_W = 5
) (
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [DATA_W-1:0]  word_o
);
    localparam int HI_W = DATA_W - CAUSE_W - EXC_LSB;
    assign word_o = {{HI_W{1'b0}}, cause_i, {EXC_LSB{1'b0}}};
endmodule

// File: rtl/exc_entry_upd.sv
module exc_entry_upd
    import exc_entry_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CAUSE_W = 5,
    parameter bit MMU_EN  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic               brk_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [DATA_W-1:0]  vec_i,
    input  logic [DATA_W-1:0]  pc_i,
    input  logic [DATA_W-1:0]  status_i,
    input  logic [DATA_W-1:0]  tlbmisc_i,
    input  logic [DATA_W-1:0]  tlb_set_i,
    output logic [DATA_W-1:0]  status_o,
    output logic [DATA_W-1:0]  estatus_o,
    output logic [DATA_W-1:0]  bstatus_o,
    output logic [DATA_W-1:0]  exc_o,
    output logic [DATA_W-1:0]  ea_o,
    output logic [DATA_W-1:0]  ba_o,
    output logic [DATA_W-1:0]  tlbmisc_o,
    output logic [DATA_W-1:0]  pc_o,
    output logic [RS_W-1:0]    bank_o
);
    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] estatus;
        logic [DATA_W-1:0] bstatus;
        logic [DATA_W-1:0] exc;
        logic [DATA_W-1:0] ea;
        logic [DATA_W-1:0] ba;
        logic [DATA_W-1:0] tlb;
        logic [DATA_W-1:0] pc;
        logic [RS_W-1:0]   bank;
    } st_t;

    st_t st_d, st_q;

    logic [DATA_W-1:0] stat_new;
    logic              nested;
    logic [DATA_W-1:0] tlb_new;
    logic [DATA_W-1:0] exc_new;

    exc_stat_next #(.DATA_W(DATA_W), .MMU_EN(MMU_EN)) u_stat (
        .old_i    (status_i),
        .new_o    (stat_new),
        .nested_o (nested)
    );

    exc_tlb_next #(.DATA_W(DATA_W), .MMU_EN(MMU_EN)) u_tlb (
        .tlb_i    (tlbmisc_i),
        .set_i    (tlb_set_i),
        .nested_i (nested),
        .tlb_o    (tlb_new)
    );

    exc_cause_fmt #(.DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u_cause (
        .cause_i (cause_i),
        .word_o  (exc_new)
    );

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.status = stat_new;
            st_d.tlb    = tlb_new;
            st_d.pc     = vec_i;
            st_d.bank   = '0;
            if (!nested) begin
                if (brk_i) begin
                    st_d.bstatus = status_i;
                    st_d.ba      = pc_i;
                end else begin
                    st_d.estatus = status_i;
                    st_d.ea      = pc_i;
                end
            end
            if (!brk_i) begin
                st_d.exc = exc_new;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o  = st_q.status;
    assign estatus_o = st_q.estatus;
    assign bstatus_o = st_q.bstatus;
    assign exc_o     = st_q.exc;
    assign ea_o      = st_q.ea;
    assign ba_o      = st_q.ba;
    assign tlbmisc_o = st_q.tlb;
    assign pc_o      = st_q.pc;
    assign bank_o    = st_q.bank;

    a_r1_cur_set_zero: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (status_o[ST_CUR_LSB +: RS_W] == '0) && (bank_o == '0));

    a_r2_nested_no_save: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && status_i[ST_HND]) |=> $stable(estatus_o) && $stable(ea_o)
                                         && $stable(bstatus_o) && $stable(ba_o));

    a_r3_brk_link: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && brk_i && !status_i[ST_HND]) |=> (ba_o == $past(pc_i)) && $stable(ea_o));

    a_r6_pie_user_clear: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !status_o[ST_PIE] && !status_o[ST_USER]);

    a_r7_brk_keeps_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && brk_i) |=> $stable(exc_o));

    a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> pc_o == $past(vec_i));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(status_o) && $stable(pc_o) && $stable(tlbmisc_o) && $stable(exc_o));
endmodule

// File: tb/exc_entry_upd_bench.sv
module exc_entry_upd_bench;
    localparam int DW = 32;
    localparam int CW = 5;

    typedef struct packed {
        logic [31:0] st;
        logic [31:0] pc;
        logic [31:0] tlb;
        logic        brk;
        logic [4:0]  cause;
        logic [31:0] vec;
        logic [31:0] set;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{32'h0000_2C03, 32'h0000_0100, 32'hFFFF_FFFF, 1'b0, 5'd12, 32'h0000_0020, 32'h0000_0005},
        '{32'h0000_0C07, 32'h0000_0204, 32'h0000_00F0, 1'b0, 5'd3,  32'h0000_0040, 32'h0000_000F},
        '{32'h0040_FC01, 32'h0000_0308, 32'h1234_567A, 1'b1, 5'd9,  32'h0000_0060, 32'h0000_0002},
        '{32'h0000_0404, 32'h0000_040C, 32'h0000_000F, 1'b1, 5'd17, 32'h0000_0080, 32'h0000_0001},
        '{32'h003F_1000, 32'h0000_0510, 32'hA5A5_A5A5, 1'b0, 5'd31, 32'h0000_00A0, 32'h8000_0000},
        '{32'hFFFF_FFFB, 32'hDEAD_BEEC, 32'h0000_0000, 1'b0, 5'd0,  32'hFFFF_FFFC, 32'h0000_000C}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic take = 1'b0, brk = 1'b0;
    logic [CW-1:0] cause = '0;
    logic [DW-1:0] vec = '0, pc = '0, st = '0, tlb = '0, tset = '0;
    logic [DW-1:0] o_st, o_est, o_bst, o_exc, o_ea, o_ba, o_tlb, o_pc;
    logic [5:0]    o_bank;
    logic [DW-1:0] n_st, n_est, n_bst, n_exc, n_ea, n_ba, n_tlb, n_pc;
    logic [5:0]    n_bank;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] m_st, m_est, m_bst, m_exc, m_ea, m_ba, m_tlb, m_pc;
    logic [5:0]    m_bank;

    always #5 clk = ~clk;

    exc_entry_upd #(.DATA_W(DW), .CAUSE_W(CW), .MMU_EN(1'b1)) u_exc_entry_upd (
        .clk(clk), .rst_n(rst_n), .take_i(take), .brk_i(brk), .cause_i(cause),
        .vec_i(vec), .pc_i(pc), .status_i(st), .tlbmisc_i(tlb), .tlb_set_i(tset),
        .status_o(o_st), .estatus_o(o_est), .bstatus_o(o_bst), .exc_o(o_exc),
        .ea_o(o_ea), .ba_o(o_ba), .tlbmisc_o(o_tlb), .pc_o(o_pc), .bank_o(o_bank)
    );

    exc_entry_upd #(.DATA_W(DW), .CAUSE_W(CW), .MMU_EN(1'b0)) u_nommu (
        .clk(clk), .rst_n(rst_n), .take_i(take), .brk_i(brk), .cause_i(cause),
        .vec_i(vec), .pc_i(pc), .status_i(st), .tlbmisc_i(tlb), .tlb_set_i(tset),
        .status_o(n_st), .estatus_o(n_est), .bstatus_o(n_bst), .exc_o(n_exc),
        .ea_o(n_ea), .ba_o(n_ba), .tlbmisc_o(n_tlb), .pc_o(n_pc), .bank_o(n_bank)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_status(input logic [DW-1:0] s, input bit mmu);
        logic [DW-1:0] r;
        r = s;
        r[15:10] = 6'd0;
        if (!s[2]) begin
            if (mmu) r[2] = 1'b1;
            r[21:16] = s[15:10];
        end
        r[0] = 1'b0;
        r[1] = 1'b0;
        return r;
    endfunction

    task automatic model(input vec_t v);
        if (!v.st[2]) begin
            if (v.brk) begin m_bst = v.st; m_ba = v.pc; end
            else begin m_est = v.st; m_ea = v.pc; end
        end
        if (!v.brk) m_exc = {25'd0, v.cause, 2'b00};
        m_tlb  = v.st[2] ? v.tlb : ((v.tlb & 32'hFFFF_FFF0) | v.set);
        m_st   = exp_status(v.st, 1'b1);
        m_pc   = v.vec;
        m_bank = 6'd0;
    endtask

    task automatic enter(input vec_t v);
        @(negedge clk);
        take = 1'b1; brk = v.brk; cause = v.cause; vec = v.vec; pc = v.pc;
        st = v.st; tlb = v.tlb; tset = v.set;
        @(negedge clk);
        take = 1'b0;
        model(v);
    endtask

    task automatic check_all(input string ctx);
        chk({ctx, " R1 R5 R6 status"}, o_st, m_st);
        chk({ctx, " R1 bank"}, {26'd0, o_bank}, {26'd0, m_bank});
        chk({ctx, " R2 R3 estatus"}, o_est, m_est);
        chk({ctx, " R2 R3 bstatus"}, o_bst, m_bst);
        chk({ctx, " R2 R3 ea"}, o_ea, m_ea);
        chk({ctx, " R2 R3 ba"}, o_ba, m_ba);
        chk({ctx, " R7 exc"}, o_exc, m_exc);
        chk({ctx, " R4 tlbmisc"}, o_tlb, m_tlb);
        chk({ctx, " R8 pc"}, o_pc, m_pc);
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_st = '0; m_est = '0; m_bst = '0; m_exc = '0; m_ea = '0; m_ba = '0;
        m_tlb = '0; m_pc = '0; m_bank = '0;
        repeat (3) @(negedge clk);
        check_all("R10 reset");
        chk("R10 reset nommu status", n_st, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            enter(TBL[i]);
            check_all($sformatf("vec%0d", i));
        end

        // R9: inputs move while take stays low
        @(negedge clk);
        st = 32'h0000_0003; pc = 32'h1111_1110; vec = 32'h2222_2220;
        tlb = 32'h3333_3333; tset = 32'hF; brk = 1'b0; cause = 5'd7;
        repeat (3) @(negedge clk);
        check_all("R9 hold");

        // R1 R5: previous set field overwritten from nonzero current set
        enter('{32'h0015_7C00, 32'h0000_0600, 32'h0, 1'b0, 5'd4, 32'h0000_0100, 32'h0});
        chk("R5 prev set field", {26'd0, o_st[21:16]}, 32'd31);
        chk("R1 cur set field", {26'd0, o_st[15:10]}, 32'd0);
        chk("R4 handler bit set", {31'd0, o_st[2]}, 32'd1);

        // nested break right after first-level break
        enter('{32'h0000_0800, 32'h0000_0700, 32'h0, 1'b1, 5'd1, 32'h0000_0120, 32'h1});
        enter('{32'h0000_0C04, 32'h0000_0800, 32'h0, 1'b1, 5'd1, 32'h0000_0140, 32'h1});
        check_all("R2 nested break");
        chk("R2 ba kept from first break", o_ba, 32'h0000_0700);

        // R11: translation unit absent
        enter('{32'h0000_0C03, 32'h0000_0900, 32'h0000_00FF, 1'b0, 5'd2, 32'h0000_0160, 32'h0000_0F00});
        chk("R11 nommu status", n_st, exp_status(32'h0000_0C03, 1'b0));
        chk("R11 nommu handler bit clear", {31'd0, n_st[2]}, 32'd0);
        chk("R11 nommu tlbmisc", n_tlb, 32'h0000_00FF);
        chk("R11 nommu ea", n_ea, 32'h0000_0900);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule